// File: doc/BRIEF.md
# Black-Level Clamp Pulse Generator

This block produces an active-low clamp strobe once per video line. The strobe tells an analog front end when the incoming video sits at black level, so that the front end can take its black reference during the low time. Timing is counted in pixel clocks from the falling edge of the horizontal sync input. The start and end offsets of the low window are taken from a small table indexed by a 2-bit code that describes the pixel clock frequency range.

A select input chooses the source of the strobe. When the select is high, the internal generator drives the output. When it is low, a clamp strobe supplied from outside is registered and passed straight through. The code value 00 is not allowed for internal generation. With that code the output stays inactive and an error flag is raised. A new sync edge that arrives while a strobe is low cuts the strobe short and starts a fresh count.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `clamp_n` is 1 and `code_err` is 0.
- R2: Let E0 be the rising clock edge at which `hsync_n` is first sampled low after being sampled high, and Ek the k-th edge after it. With `clamp_sel`=1 and `rng_code`=01, `clamp_n` is 0 after edges E32 through E43 and 1 at all other edges of the line (12 clocks low).
- R3: Under the same conditions with `rng_code`=10, `clamp_n` is 0 after edges E22 through E33 (12 clocks low).
- R4: Under the same conditions with `rng_code`=11, `clamp_n` is 0 after edges E18 through E27 (10 clocks low).
- R5: When `clamp_sel`=1 and `rng_code`=00 are sampled at an edge, then after that edge `clamp_n` is 1 and `code_err` is 1. In every other case `code_err` is 0 after the edge.
- R6: When `clamp_sel`=0 is sampled at an edge, then after that edge `clamp_n` equals the value of `ext_clamp_n` sampled at that edge. No internal strobe appears.
- R7: A new falling sync edge sampled while the strobe is low drives `clamp_n` to 1 at that same edge E0. The window then restarts from that edge as in R2 to R4.
- R8: Only a high-to-low change of `hsync_n` starts a line. Holding `hsync_n` low or raising it produces no further strobe, and `clamp_n` stays 1 after a window has ended until the next falling edge.
- R9: After reset, and before the first falling sync edge, no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low, synchronous to clk |
| rng_code | input | 2 | Clock-range code selecting the window offsets |
| clamp_sel | input | 1 | 1: internal generator, 0: external strobe |
| ext_clamp_n | input | 1 | External active-low clamp strobe |
| clamp_n | output | 1 | Registered active-low clamp strobe |
| code_err | output | 1 | Prohibited code used with the internal generator |

## Verification
On every cycle the assertions check the following: a forbidden code forces the strobe inactive and raises the flag; the external path reproduces its input one clock later; a fresh sync edge ends an internal strobe; and an idle, saturated counter never produces a low output. The line counter is also checked to step by exactly one between sync edges. Only the bench scenarios show that each code places its window at the exact clock offsets and width. The same holds for a restart in the middle of a strobe, a long low sync that does not retrigger, and the quiet period after reset. These properties span dozens of cycles and depend on the table contents.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    localparam int OFS_W = 6;

    typedef enum logic [1:0] {
        RNG_BAD = 2'b00,
        RNG_HI  = 2'b01,
        RNG_MID = 2'b10,
        RNG_LO  = 2'b11
    } rng_code_e;

    // Low window: [first, last) counted in clocks from the sync fall
    typedef struct packed {
        logic             ok;
        logic [OFS_W-1:0] first;
        logic [OFS_W-1:0] last;
    } win_t;

    typedef struct packed {
        logic clamp_n;
        logic err;
    } out_st_t;

    function automatic win_t win_lookup(input logic [1:0] code);
        win_t w;
        w.ok    = 1'b1;
        w.first = '0;
        w.last  = '0;
        case (rng_code_e'(code))
            RNG_HI:  begin w.first = OFS_W'(32); w.last = OFS_W'(44); end
            RNG_MID: begin w.first = OFS_W'(22); w.last = OFS_W'(34); end
            RNG_LO:  begin w.first = OFS_W'(18); w.last = OFS_W'(28); end
            default: w.ok = 1'b0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/clamp_fall_detect.sv
module clamp_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic fall
);

    logic hs_d, hs_q;

    always_comb begin
        hs_d = sync_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= 1'b1;
        else        hs_q <= hs_d;
    end

    assign fall = hs_q & ~sync_n;

    // R8
    fall_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/clamp_line_counter.sv
module clamp_line_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_comb begin
        if (restart)               cnt_d = '0;
        else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
        else                       cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_MAX;
        else        cnt_q <= cnt_d;
    end

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/clamp_window.sv
module clamp_window
    import clamp_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [1:0]       code,
    input  logic [CNT_W-1:0] cnt,
    output logic             in_win,
    output logic             bad_code
);

    win_t w;

    always_comb begin
        w        = win_lookup(code);
        bad_code = ~w.ok;
        in_win   = w.ok && (cnt >= CNT_W'(w.first)) && (cnt < CNT_W'(w.last));
    end

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import clamp_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_n,
    input  logic [1:0] rng_code,
    input  logic       clamp_sel,
    input  logic       ext_clamp_n,
    output logic       clamp_n,
    output logic       code_err
);

    localparam logic [CNT_W-1:0] CNT_IDLE = '1;

    logic             fall;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             in_win, bad_code;
    out_st_t          st_d, st_q;

    clamp_fall_detect u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_n (hsync_n),
        .fall   (fall)
    );

    clamp_line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fall),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d)
    );

    // Window is judged on the count value that will hold after this edge
    clamp_window #(.CNT_W(CNT_W)) u_win (
        .code     (rng_code),
        .cnt      (cnt_d),
        .in_win   (in_win),
        .bad_code (bad_code)
    );

    always_comb begin
        st_d = st_q;
        if (!clamp_sel) begin
            st_d.clamp_n = ext_clamp_n;
            st_d.err     = 1'b0;
        end else begin
            st_d.clamp_n = ~in_win;
            st_d.err     = bad_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.clamp_n <= 1'b1;
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clamp_n  = st_q.clamp_n;
    assign code_err = st_q.err;

    // R5
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_sel && rng_code == 2'b00) |=> (clamp_n && code_err));

    // R6
    ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_sel |=> (clamp_n == $past(ext_clamp_n) && !code_err));

    // R7
    restart_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && clamp_sel) |=> clamp_n);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_sel && !fall && cnt_q == CNT_IDLE) |=> clamp_n);

endmodule

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hsync_n;
    logic [1:0] rng_code;
    logic       clamp_sel;
    logic       ext_clamp_n;
    logic       clamp_n;
    logic       code_err;

    int   total = 0;
    int   bad   = 0;
    int   k     = 1000;
    logic prev_hs = 1'b1;

    always #5 clk = ~clk;

    clamp_pulse_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_n     (hsync_n),
        .rng_code    (rng_code),
        .clamp_sel   (clamp_sel),
        .ext_clamp_n (ext_clamp_n),
        .clamp_n     (clamp_n),
        .code_err    (code_err)
    );

    function automatic int win_lo(input logic [1:0] c);
        case (c)
            2'b01:   return 32;
            2'b10:   return 22;
            2'b11:   return 18;
            default: return 0;
        endcase
    endfunction

    function automatic int win_hi(input logic [1:0] c);
        case (c)
            2'b01:   return 44;
            2'b10:   return 34;
            2'b11:   return 28;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_clamp(input logic sel, input logic [1:0] c,
                                       input int kk, input logic ext);
        if (!sel)     return ext;
        if (c == 2'b00) return 1'b1;
        return !(kk >= win_lo(c) && kk < win_hi(c));
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic hs, input logic [1:0] c, input logic sel,
                        input logic ext, input string tag);
        @(negedge clk);
        hsync_n     = hs;
        rng_code    = c;
        clamp_sel   = sel;
        ext_clamp_n = ext;
        @(posedge clk);
        if (prev_hs && !hs) k = 0;
        else if (k < 1000)  k++;
        prev_hs = hs;
        #1;
        check(tag, "clamp_n", clamp_n, exp_clamp(sel, c, k, ext));
        check(tag, "code_err", code_err, sel && (c == 2'b00));
    endtask

    task automatic run_line(input logic [1:0] c, input logic sel, input int low_w,
                            input int len, input string tag);
        for (int i = 0; i < len; i++)
            step((i < low_w) ? 1'b0 : 1'b1, c, sel, sel ? 1'b1 : 1'($urandom % 2), tag);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; hsync_n = 1'b1; rng_code = 2'b01;
        clamp_sel = 1'b1; ext_clamp_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "clamp_n", clamp_n, 1'b1);
        check("R1", "code_err", code_err, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "clamp_n", clamp_n, 1'b1);
        check("R1", "code_err", code_err, 1'b0);

        // R9: quiet until the first sync fall
        for (int i = 0; i < 60; i++) step(1'b1, 2'b01, 1'b1, 1'b1, "R9");

        run_line(2'b01, 1'b1, 4, 60, "R2");
        run_line(2'b10, 1'b1, 4, 60, "R3");
        run_line(2'b11, 1'b1, 4, 60, "R4");
        run_line(2'b00, 1'b1, 4, 60, "R5");
        run_line(2'b01, 1'b0, 4, 60, "R6");

        // R7: second fall at k=36, inside the 32..43 window
        step(1'b0, 2'b01, 1'b1, 1'b1, "R7");
        for (int i = 1; i < 36; i++) step(1'b1, 2'b01, 1'b1, 1'b1, "R7");
        run_line(2'b01, 1'b1, 2, 60, "R7");

        // R8: long low sync, then high; exactly one strobe
        run_line(2'b11, 1'b1, 100, 150, "R8");

        for (int n = 0; n < 40; n++) begin
            logic [1:0] c;
            logic       sel;
            c   = ($urandom % 8 == 0) ? 2'b00 : 2'(1 + $urandom % 3);
            sel = ($urandom % 6 != 0);
            run_line(c, sel, 1 + int'($urandom % 8), 46 + int'($urandom % 60),
                     !sel ? "R6" : (c == 2'b00) ? "R5" :
                     (c == 2'b01) ? "R2" : (c == 2'b10) ? "R3" : "R4");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule